// File: doc/BRIEF.md
# Video Controller Register Read Port

This block answers processor reads of a tile-based video controller's register window. A read is offered with an address on a valid/ready request channel. One cycle after it is accepted, a response comes out with a single-cycle valid pulse. The response carries one of four things: the status flags, a byte of sprite attribute memory, a byte from the video address space, or zero with an error pulse when the address is not a readable register.

Video-space reads use the block's own 15-bit video address pointer, not the processor address. They return the contents of a one-byte read buffer. The byte at the pointer is then fetched into that buffer and the pointer steps forward by 1 or by 32. The low 8 KiB of video space comes from an external character ROM port. The next 8 KiB folds onto 2 KiB of nametable RAM, which sits behind an external port, under a horizontal or vertical mirroring mode. All three memories (character ROM, nametable RAM and sprite attribute memory) are synchronous, with one cycle of read latency.

The response channel has no ready: the consumer must take each pulse. Back-pressure applies on the request side only. After a video data read is accepted, `req_ready` drops for exactly one cycle while the buffer refills.

Top module: `vrp_rd_port`

## Requirements
- R1: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `rsp_valid` is high for exactly the one cycle that follows each accepted request, and is never high at any other time.
- R2: A read of address 0x2002 returns vblank in bit 7, sprite-0 hit in bit 6 and sprite overflow in bit 5, with bits 4..0 zero. The flag values are those held before the read's own side effects.
- R3: An accepted read of 0x2002 clears the vblank flag and the write toggle `wt_q`. A `vbl_set` pulse in the same cycle leaves vblank set. The clear takes precedence over a same-cycle `wt_flip`.
- R4: `vbl_set`, `hit_set` and `ovf_set` each set their flag. `flags_clr` clears all three flags, but a set pulse in the same cycle wins. Status reads never change sprite-0 hit or sprite overflow. `wt_flip` inverts `wt_q`.
- R5: A read of 0x2004 returns the sprite attribute byte at `oam_ptr` as it was in the accepting cycle.
- R6: A read of 0x2007 returns the read buffer. The buffer is then loaded with the video-space byte at the pointer value held before the increment.
- R7: Each accepted 0x2007 read advances `v_q` by 32 when `inc_by32` is high and by 1 otherwise, wrapping at 15 bits. In the same cycle, `v_load` overrides the increment and loads `v_load_val`.
- R8: A pointer with bit 13 clear is served from the character ROM at `chr_addr = v[12:0]`. A pointer with bit 13 set is served from nametable RAM, and bits 14 and 12 are ignored.
- R9: With `mirror_vert` low (horizontal mirroring), `nt_addr = {v[11], v[9:0]}`. With `mirror_vert` high (vertical mirroring), `nt_addr = {v[10], v[9:0]}`.
- R10: In the cycle after a 0x2007 read is accepted, `req_ready` is low. It is high again in the cycle after that.
- R11: A read of any other address returns 0x00 with `rsp_err` high alongside `rsp_valid`. It leaves the pointer, toggle, flags and buffer unchanged.
- R12: Synchronous active-high `rst` clears the read buffer, the write toggle, all three flags and the pointer. After reset, no response is pending and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 16 | Processor register address |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 8 | Response byte |
| rsp_err | output | 1 | Response is for an unreadable address |
| inc_by32 | input | 1 | Pointer step of 32 instead of 1 |
| mirror_vert | input | 1 | 1 = vertical mirroring, 0 = horizontal |
| vbl_set | input | 1 | Set vblank flag |
| hit_set | input | 1 | Set sprite-0 hit flag |
| ovf_set | input | 1 | Set sprite overflow flag |
| flags_clr | input | 1 | Clear all three flags |
| wt_flip | input | 1 | Invert the write toggle |
| wt_q | output | 1 | Write toggle |
| v_load | input | 1 | Load the video pointer |
| v_load_val | input | 15 | Value to load |
| v_q | output | 15 | Current video pointer |
| oam_ptr | input | 8 | Current sprite attribute address |
| oam_re | output | 1 | Sprite attribute memory read enable |
| oam_raddr | output | 8 | Sprite attribute memory read address |
| oam_rdata | input | 8 | Sprite attribute byte, one cycle after enable |
| chr_re | output | 1 | Character ROM read enable |
| chr_addr | output | 13 | Character ROM address |
| chr_rdata | input | 8 | Character ROM byte, one cycle after enable |
| nt_re | output | 1 | Nametable RAM read enable |
| nt_addr | output | 11 | Folded nametable RAM address |
| nt_rdata | input | 8 | Nametable RAM byte, one cycle after enable |

## Verification
The bound assertions watch, on every cycle, the following invariants:
- the one-to-one pairing of accepted requests with response pulses;
- the zero low bits of a status byte;
- the toggle clearing after a status read;
- the pointer stride;
- the one-cycle ready drop after a data read;
- the zero data on error responses;
- the exclusivity of the two video memory ports.

Three behaviours span several reads, and only the bench's scenarios show them: the one-read lag through the buffer, the exact mirroring fold, and side effects that are absent. The bench sweeps the whole character range and the whole nametable range under both mirroring modes, and also a wrapping stride-32 run. It checks every returned byte against arithmetic memory contents.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
  typedef enum logic [1:0] {
    RK_STATUS = 2'd0,
    RK_OAM    = 2'd1,
    RK_DATA   = 2'd2,
    RK_NONE   = 2'd3
  } rk_e;

  typedef struct packed {
    logic vblank;
    logic hit;
    logic ovf;
  } flags_t;

  localparam int STAT_OFF = 2;
  localparam int OAM_OFF  = 4;
  localparam int DATA_OFF = 7;
endpackage

// File: rtl/vrp_decode.sv
module vrp_decode
  import vrp_pkg::*;
#(
  parameter int            AW   = 16,
  parameter logic [AW-1:0] BASE = 16'h2000
) (
  input  logic [AW-1:0] addr,
  output rk_e           kind
);
  localparam logic [AW-1:0] A_STAT = BASE + AW'(STAT_OFF);
  localparam logic [AW-1:0] A_OAM  = BASE + AW'(OAM_OFF);
  localparam logic [AW-1:0] A_DATA = BASE + AW'(DATA_OFF);

  always_comb begin
    if (addr == A_STAT)      kind = RK_STATUS;
    else if (addr == A_OAM)  kind = RK_OAM;
    else if (addr == A_DATA) kind = RK_DATA;
    else                     kind = RK_NONE;
  end
endmodule

// File: rtl/vrp_mirror.sv
// Folds a nametable-space offset onto the 2-page internal RAM.
module vrp_mirror #(
  parameter int NAW = 11
) (
  input  logic [NAW:0]   offs,
  input  logic           vert,
  output logic [NAW-1:0] ram_addr
);
  localparam int PAGE_W = NAW - 1;

  logic [1:0] table_idx;
  logic       page;

  assign table_idx = offs[NAW:PAGE_W];
  // horizontal: tables 0,1 -> page 0 ; 2,3 -> page 1
  // vertical:   tables 0,2 -> page 0 ; 1,3 -> page 1
  assign page     = vert ? table_idx[0] : table_idx[1];
  assign ram_addr = {page, offs[PAGE_W-1:0]};
endmodule

// File: rtl/vrp_status.sv
module vrp_status
  import vrp_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   vbl_set,
  input  logic   hit_set,
  input  logic   ovf_set,
  input  logic   flags_clr,
  input  logic   rd_stat,
  input  logic   wt_flip,
  output flags_t flags,
  output logic   wt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      wt    <= 1'b0;
    end else begin
      if (vbl_set)                     flags.vblank <= 1'b1;
      else if (rd_stat || flags_clr)   flags.vblank <= 1'b0;

      if (hit_set)        flags.hit <= 1'b1;
      else if (flags_clr) flags.hit <= 1'b0;

      if (ovf_set)        flags.ovf <= 1'b1;
      else if (flags_clr) flags.ovf <= 1'b0;

      if (rd_stat)      wt <= 1'b0;
      else if (wt_flip) wt <= ~wt;
    end
  end
endmodule

// File: rtl/vrp_vaddr.sv
module vrp_vaddr #(
  parameter int VAW    = 15,
  parameter int STRIDE = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [VAW-1:0] load_val,
  input  logic           step,
  input  logic           wide,
  output logic [VAW-1:0] v
);
  localparam logic [VAW-1:0] STEP_S = VAW'(1);
  localparam logic [VAW-1:0] STEP_L = VAW'(STRIDE);

  always_ff @(posedge clk) begin
    if (rst)       v <= '0;
    else if (load) v <= load_val;
    else if (step) v <= v + (wide ? STEP_L : STEP_S);
  end
endmodule

// File: rtl/vrp_rd_port.sv
module vrp_rd_port
  import vrp_pkg::*;
#(
  parameter int                 AW       = 16,
  parameter logic [AW-1:0]      REG_BASE = 16'h2000,
  parameter int                 DW       = 8,
  parameter int                 VAW      = 15,
  parameter int                 CHR_AW   = 13,
  parameter int                 NT_AW    = 11,
  parameter int                 OAM_AW   = 8,
  parameter int                 STRIDE   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  output logic              rsp_err,
  input  logic              inc_by32,
  input  logic              mirror_vert,
  input  logic              vbl_set,
  input  logic              hit_set,
  input  logic              ovf_set,
  input  logic              flags_clr,
  input  logic              wt_flip,
  output logic              wt_q,
  input  logic              v_load,
  input  logic [VAW-1:0]    v_load_val,
  output logic [VAW-1:0]    v_q,
  input  logic [OAM_AW-1:0] oam_ptr,
  output logic              oam_re,
  output logic [OAM_AW-1:0] oam_raddr,
  input  logic [DW-1:0]     oam_rdata,
  output logic              chr_re,
  output logic [CHR_AW-1:0] chr_addr,
  input  logic [DW-1:0]     chr_rdata,
  output logic              nt_re,
  output logic [NT_AW-1:0]  nt_addr,
  input  logic [DW-1:0]     nt_rdata
);
  // bit of the pointer that selects nametable space over character space
  localparam int NT_SEL = CHR_AW;
  localparam int PAD_W  = DW - 3;

  rk_e    kind;
  flags_t flags;
  logic   accept, rd_stat, rd_oam, rd_data, to_nt;

  logic          rsp_v_q;
  rk_e           kind_q;
  logic [DW-1:0] held_q;
  logic          fill_q;
  logic          fill_nt_q;
  logic [DW-1:0] rbuf_q;

  vrp_decode #(.AW(AW), .BASE(REG_BASE)) u_dec (
    .addr (req_addr),
    .kind (kind)
  );

  assign req_ready = ~fill_q;
  assign accept    = req_valid & req_ready;
  assign rd_stat   = accept & (kind == RK_STATUS);
  assign rd_oam    = accept & (kind == RK_OAM);
  assign rd_data   = accept & (kind == RK_DATA);
  assign to_nt     = v_q[NT_SEL];

  vrp_status u_stat (
    .clk       (clk),
    .rst       (rst),
    .vbl_set   (vbl_set),
    .hit_set   (hit_set),
    .ovf_set   (ovf_set),
    .flags_clr (flags_clr),
    .rd_stat   (rd_stat),
    .wt_flip   (wt_flip),
    .flags     (flags),
    .wt        (wt_q)
  );

  vrp_vaddr #(.VAW(VAW), .STRIDE(STRIDE)) u_vaddr (
    .clk      (clk),
    .rst      (rst),
    .load     (v_load),
    .load_val (v_load_val),
    .step     (rd_data),
    .wide     (inc_by32),
    .v        (v_q)
  );

  vrp_mirror #(.NAW(NT_AW)) u_mirror (
    .offs     (v_q[NT_AW:0]),
    .vert     (mirror_vert),
    .ram_addr (nt_addr)
  );

  assign chr_re    = rd_data & ~to_nt;
  assign chr_addr  = v_q[CHR_AW-1:0];
  assign nt_re     = rd_data & to_nt;
  assign oam_re    = rd_oam;
  assign oam_raddr = oam_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_v_q   <= 1'b0;
      kind_q    <= RK_NONE;
      held_q    <= '0;
      fill_q    <= 1'b0;
      fill_nt_q <= 1'b0;
      rbuf_q    <= '0;
    end else begin
      rsp_v_q   <= accept;
      fill_q    <= rd_data;
      fill_nt_q <= to_nt;
      if (accept) begin
        kind_q <= kind;
        unique case (kind)
          RK_STATUS: held_q <= {flags.vblank, flags.hit, flags.ovf, {PAD_W{1'b0}}};
          RK_DATA:   held_q <= rbuf_q;
          default:   held_q <= '0;
        endcase
      end
      if (fill_q) rbuf_q <= fill_nt_q ? nt_rdata : chr_rdata;
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_err   = rsp_v_q & (kind_q == RK_NONE);
  assign rsp_data  = !rsp_v_q          ? '0 :
                     (kind_q == RK_OAM) ? oam_rdata : held_q;
endmodule

// File: rtl/vrp_rd_port_chk.sv
module vrp_rd_port_chk #(
  parameter int            AW       = 16,
  parameter logic [AW-1:0] REG_BASE = 16'h2000,
  parameter int            DW       = 8,
  parameter int            VAW      = 15,
  parameter int            STRIDE   = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic           req_ready,
  input logic [AW-1:0]  req_addr,
  input logic           rsp_valid,
  input logic [DW-1:0]  rsp_data,
  input logic           rsp_err,
  input logic           inc_by32,
  input logic           v_load,
  input logic [VAW-1:0] v_q,
  input logic           wt_q,
  input logic           chr_re,
  input logic           nt_re
);
  localparam logic [AW-1:0] A_STAT = REG_BASE + AW'(2);
  localparam logic [AW-1:0] A_DATA = REG_BASE + AW'(7);

  logic acc;
  assign acc = req_valid && req_ready;

  a_r1_rsp_after_accept: assert property (@(posedge clk) disable iff (rst)
    acc |=> rsp_valid);
  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(acc));
  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (acc && req_addr == A_STAT) |=> (rsp_data[DW-4:0] == '0));
  a_r3_toggle_cleared: assert property (@(posedge clk) disable iff (rst)
    (acc && req_addr == A_STAT) |=> !wt_q);
  a_r7_stride: assert property (@(posedge clk) disable iff (rst)
    (acc && req_addr == A_DATA && !v_load) |=>
      (v_q == $past(v_q) + ($past(inc_by32) ? VAW'(STRIDE) : VAW'(1))));
  a_r8_one_memory: assert property (@(posedge clk) disable iff (rst)
    !(chr_re && nt_re));
  a_r10_refill_stall: assert property (@(posedge clk) disable iff (rst)
    (acc && req_addr == A_DATA) |=> !req_ready);
  a_r11_err_is_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && rsp_data == '0));
endmodule

bind vrp_rd_port vrp_rd_port_chk #(
  .AW(AW), .REG_BASE(REG_BASE), .DW(DW), .VAW(VAW), .STRIDE(STRIDE)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .rsp_err(rsp_err), .inc_by32(inc_by32), .v_load(v_load), .v_q(v_q),
  .wt_q(wt_q), .chr_re(chr_re), .nt_re(nt_re)
);

// File: tb/vrp_rd_port_bench.sv
module vrp_rd_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        rsp_err;
  logic        inc_by32 = 1'b0, mirror_vert = 1'b0;
  logic        vbl_set = 1'b0, hit_set = 1'b0, ovf_set = 1'b0, flags_clr = 1'b0;
  logic        wt_flip = 1'b0;
  logic        wt_q;
  logic        v_load = 1'b0;
  logic [14:0] v_load_val = '0;
  logic [14:0] v_q;
  logic [7:0]  oam_ptr = '0;
  logic        oam_re;
  logic [7:0]  oam_raddr;
  logic [7:0]  oam_rdata = '0;
  logic        chr_re;
  logic [12:0] chr_addr;
  logic [7:0]  chr_rdata = '0;
  logic        nt_re;
  logic [10:0] nt_addr;
  logic [7:0]  nt_rdata = '0;

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [7:0]  exp_buf = '0;
  logic [14:0] ev = '0;

  always #2.5 clk = ~clk;

  vrp_rd_port u_vrp_rd_port (.*);

  function automatic logic [7:0] chr_fn(input logic [12:0] a);
    return a[7:0] ^ (8'(a[12:8]) * 8'd29);
  endfunction
  function automatic logic [7:0] nt_fn(input logic [10:0] a);
    return (a[7:0] + 8'(a[10:8]) * 8'd37) ^ 8'h5A;
  endfunction
  function automatic logic [7:0] oam_fn(input logic [7:0] a);
    return (a * 8'd7) ^ 8'hC3;
  endfunction
  // expected video-space byte from R8/R9
  function automatic logic [7:0] vmem(input logic [14:0] v, input logic vert);
    if (!v[13]) return chr_fn(v[12:0]);
    return nt_fn({vert ? v[10] : v[11], v[9:0]});
  endfunction

  always @(posedge clk) begin
    chr_rdata <= chr_fn(chr_addr);
    nt_rdata  <= nt_fn(nt_addr);
    oam_rdata <= oam_fn(oam_raddr);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d, output logic e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R1 response pulse", int'(rsp_valid), 1);
    if (a == 16'h2007) chk(req_ready === 1'b0, "R10 ready low after data read", int'(req_ready), 0);
    d = rsp_data;
    e = rsp_err;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R1 single pulse", int'(rsp_valid), 0);
  endtask

  task automatic data_rd(input string tag);
    logic [7:0] d;
    logic e;
    logic [7:0] want;
    want = exp_buf;
    exp_buf = vmem(ev, mirror_vert);
    ev = ev + (inc_by32 ? 15'd32 : 15'd1);
    rd(16'h2007, d, e);
    chk(d === want && e === 1'b0, tag, int'(d), int'(want));
    chk(v_q === ev, "R7 pointer step", int'(v_q), int'(ev));
  endtask

  task automatic loadv(input logic [14:0] val);
    @(negedge clk);
    v_load = 1'b1;
    v_load_val = val;
    @(negedge clk);
    v_load = 1'b0;
    ev = val;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic e;
    logic [14:0] vsave;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk(rsp_valid === 1'b0, "R12 no response", int'(rsp_valid), 0);
    chk(req_ready === 1'b1, "R12 ready", int'(req_ready), 1);
    chk(wt_q === 1'b0, "R12 toggle", int'(wt_q), 0);
    chk(v_q === 15'd0, "R12 pointer", int'(v_q), 0);
    rd(16'h2002, d, e);
    chk(d === 8'h00, "R12 flags clear", int'(d), 0);
    data_rd("R12 buffer clear");

    // R2/R3: vblank
    pulse(vbl_set);
    rd(16'h2002, d, e);
    chk(d === 8'h80, "R2 vblank bit", int'(d), 8'h80);
    rd(16'h2002, d, e);
    chk(d === 8'h00, "R3 vblank cleared by read", int'(d), 0);
    // R3: set and read in same cycle, set wins, read sees old value
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h2002; vbl_set = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; vbl_set = 1'b0;
    chk(rsp_data === 8'h00, "R3 same-cycle read sees old", int'(rsp_data), 0);
    rd(16'h2002, d, e);
    chk(d === 8'h80, "R3 same-cycle set wins", int'(d), 8'h80);

    // R4: hit/overflow persist across status reads, cleared by flags_clr
    pulse(hit_set);
    pulse(ovf_set);
    rd(16'h2002, d, e);
    chk(d === 8'h60, "R4 hit and overflow", int'(d), 8'h60);
    rd(16'h2002, d, e);
    chk(d === 8'h60, "R4 not cleared by read", int'(d), 8'h60);
    pulse(flags_clr);
    rd(16'h2002, d, e);
    chk(d === 8'h00, "R4 flags_clr", int'(d), 0);
    @(negedge clk);
    flags_clr = 1'b1; hit_set = 1'b1;
    @(negedge clk);
    flags_clr = 1'b0; hit_set = 1'b0;
    rd(16'h2002, d, e);
    chk(d === 8'h40, "R4 set beats clear", int'(d), 8'h40);
    pulse(flags_clr);

    // R3/R4: write toggle
    pulse(wt_flip);
    chk(wt_q === 1'b1, "R4 toggle flips", int'(wt_q), 1);
    rd(16'h2002, d, e);
    chk(wt_q === 1'b0, "R3 toggle cleared", int'(wt_q), 0);
    pulse(wt_flip);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h2002; wt_flip = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; wt_flip = 1'b0;
    chk(wt_q === 1'b0, "R3 clear beats flip", int'(wt_q), 0);

    // R5: sprite attribute sweep
    for (int i = 0; i < 256; i++) begin
      oam_ptr = 8'(i);
      rd(16'h2004, d, e);
      chk(d === oam_fn(8'(i)) && e === 1'b0, "R5 attribute byte", int'(d), int'(oam_fn(8'(i))));
    end

    // R6/R8: full character range
    loadv(15'h0000);
    for (int i = 0; i < 8192; i++) data_rd("R6 R8 character byte");

    // R9: full nametable range in both mirroring modes (through 0x3xxx fold)
    for (int m = 0; m < 2; m++) begin
      mirror_vert = 1'(m);
      loadv(15'h2000);
      for (int i = 0; i < 4096; i++) data_rd("R9 nametable byte");
      loadv(15'h7400);
      for (int i = 0; i < 64; i++) data_rd("R8 R9 high fold");
    end

    // R7: stride 32 with 15-bit wrap
    inc_by32 = 1'b1;
    loadv(15'h7C07);
    for (int i = 0; i < 96; i++) data_rd("R7 stride 32");
    inc_by32 = 1'b0;

    // R7: load overrides increment
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h2007; v_load = 1'b1; v_load_val = 15'h2123;
    @(negedge clk);
    req_valid = 1'b0; v_load = 1'b0;
    chk(v_q === 15'h2123, "R7 load wins", int'(v_q), 15'h2123);
    chk(rsp_data === exp_buf, "R6 buffer on load cycle", int'(rsp_data), int'(exp_buf));
    exp_buf = vmem(ev, mirror_vert);
    ev = 15'h2123;
    @(negedge clk);
    chk(req_ready === 1'b1, "R10 ready back", int'(req_ready), 1);

    // R11: unreadable addresses have no side effects
    pulse(vbl_set);
    pulse(wt_flip);
    vsave = v_q;
    for (int i = 0; i < 10; i++) begin
      logic [15:0] a;
      a = (i < 8) ? 16'h2000 + 16'(i) : ((i == 8) ? 16'h0007 : 16'hA007);
      if (a != 16'h2002 && a != 16'h2004 && a != 16'h2007) begin
        rd(a, d, e);
        chk(d === 8'h00 && e === 1'b1, "R11 zero with error", int'({e, d}), 9'h100);
      end
    end
    chk(v_q === vsave, "R11 pointer kept", int'(v_q), int'(vsave));
    chk(wt_q === 1'b1, "R11 toggle kept", int'(wt_q), 1);
    data_rd("R11 buffer kept");
    rd(16'h2002, d, e);
    chk(d === 8'h80 && e === 1'b0, "R11 flags kept", int'(d), 8'h80);

    // R12: reset mid-run
    pulse(vbl_set);
    pulse(wt_flip);
    loadv(15'h0055);
    data_rd("R6 pre-reset read");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_buf = '0;
    ev = '0;
    chk(wt_q === 1'b0, "R12 toggle after reset", int'(wt_q), 0);
    chk(v_q === 15'd0, "R12 pointer after reset", int'(v_q), 0);
    rd(16'h2002, d, e);
    chk(d === 8'h00, "R12 flags after reset", int'(d), 0);
    data_rd("R12 buffer after reset");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule